// File: doc/BRIEF.md
# Strobed Output Handshake Port

This block is a byte-wide output port that hands data to a receiving device, a printer for example, under a two-wire handshake. A CPU write strobe captures a byte onto the port's data outputs. The same write pulls an active-low buffer-full line low. That line drives the receiver's strobe input and tells it a fresh byte is waiting.

The receiver answers by pulling its active-low acknowledge line low. The acknowledge input first passes through a synchronizer chain. While the synchronized acknowledge is low, the port lifts buffer-full high to mark the byte as taken. When acknowledge returns high, the port raises an interrupt request, provided the interrupt-enable input is set and buffer-full is already high. The interrupt tells the CPU that it may send the next byte. The next CPU write clears the interrupt and starts the cycle again.

A three-bit status output lets the CPU read the present flag and enable state.

Top module: `hs_strobe_out_port`

## Requirements
- R1: After synchronous reset, obf_n is 1, irq is 0 and port_data is 0.
- R2: A cycle with wr_stb high loads wr_data into port_data and drives obf_n to 0, both visible after that clock edge.
- R3: ack_n passes through SYNC_STAGES (default 2) flip-flops. Once the synchronized level is 0, obf_n goes to 1 on the next edge, so the change shows three edges after ack_n falls. port_data is left unchanged.
- R4: Once obf_n is 1, it stays 1 through any number of further acknowledge pulses until the next write.
- R5: A rising edge of the synchronized ack_n sets irq when int_en is 1 and obf_n is 1. The result shows three edges after ack_n rises.
- R6: A rising acknowledge edge while int_en is 0 leaves irq at 0.
- R7: A write clears irq on the same edge that loads the data.
- R8: int_en at 0 forces irq to 0 within the same cycle, with no clock edge needed. The pending request is also discarded, so setting int_en back to 1 does not bring irq back.
- R9: status[2] equals obf_n, status[1] equals irq and status[0] equals int_en.
- R10: When a write and a synchronized-low acknowledge fall on the same edge, the write wins and obf_n goes to 0. While acknowledge stays low, obf_n returns to 1 on the following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_stb | input | 1 | CPU write strobe, one cycle per byte |
| wr_data | input | DATA_W | Byte written by the CPU |
| int_en | input | 1 | Interrupt enable |
| ack_n | input | 1 | Receiver acknowledge, active low, asynchronous |
| obf_n | output | 1 | Buffer full, active low, drives the receiver strobe |
| irq | output | 1 | Interrupt request to the CPU |
| port_data | output | DATA_W | Latched byte toward the receiver |
| status | output | 3 | Status read: {obf_n, irq, int_en} |

## Verification
The handshake is run through several distinct sequences:
- A plain write, acknowledge low, acknowledge high cycle, which separates the buffer-full release from the interrupt set and pins down the synchronizer latency.
- A cycle with the enable off and a repeat acknowledge with buffer-full already high, which separate the enable gate from the hold of buffer-full.
- A write landing while acknowledge is held low, which shows write priority and the re-release that follows.
- Dropping the enable while a request is pending, which shows the immediate masking and that the request is discarded rather than hidden.

// File: rtl/hs_pkg.sv
package hs_pkg;
  localparam int STAT_W = 3;
  typedef struct packed {
    logic obf_n;
    logic irq;
    logic en;
  } hs_status_t;
endpackage

// File: rtl/hs_ack_sync.sv
module hs_ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ack_n_i,
  output logic ack_lvl_o,
  output logic ack_rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b1;
          else     chain_q[g] <= ack_n_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b1;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= chain_q[STAGES-1];
  end

  assign ack_lvl_o  = chain_q[STAGES-1];
  assign ack_rise_o = chain_q[STAGES-1] & ~prev_q;

  // R5: an edge pulse is one cycle wide
  assert_rise_single_R5: assert property (@(posedge clk) disable iff (rst)
    ack_rise_o |=> !ack_rise_o);
endmodule

// File: rtl/hs_data_reg.sv
module hs_data_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst)         q_o <= '0;
    else if (load_i) q_o <= d_i;
  end

  assert_data_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(q_o));
  assert_data_load_R2: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (q_o == $past(d_i)));
endmodule

// File: rtl/hs_flags.sv
module hs_flags (
  input  logic clk,
  input  logic rst,
  input  logic wr_i,
  input  logic en_i,
  input  logic ack_lvl_i,
  input  logic ack_rise_i,
  output logic obf_n_o,
  output logic irq_o
);
  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst)             obf_n_o <= 1'b1;
    else if (wr_i)       obf_n_o <= 1'b0;
    else if (!ack_lvl_i) obf_n_o <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                                      irq_q <= 1'b0;
    else if (wr_i || !en_i)                       irq_q <= 1'b0;
    else if (ack_rise_i && ack_lvl_i && obf_n_o)  irq_q <= 1'b1;
  end

  assign irq_o = irq_q & en_i;

  assert_wr_obf_R2: assert property (@(posedge clk) disable iff (rst)
    wr_i |=> !obf_n_o);
  assert_ack_release_R3: assert property (@(posedge clk) disable iff (rst)
    (!ack_lvl_i && !wr_i) |=> obf_n_o);
  assert_obf_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (obf_n_o && !wr_i) |=> obf_n_o);
  assert_irq_cause_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> (obf_n_o && $past(en_i)));
  assert_wr_irq_R7: assert property (@(posedge clk) disable iff (rst)
    wr_i |=> !irq_q);
  assert_en_drop_R8: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !irq_q);
endmodule

// File: rtl/hs_strobe_out_port.sv
module hs_strobe_out_port #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              int_en,
  input  logic              ack_n,
  output logic              obf_n,
  output logic              irq,
  output logic [DATA_W-1:0] port_data,
  output logic [hs_pkg::STAT_W-1:0] status
);
  import hs_pkg::*;

  logic       ack_lvl;
  logic       ack_rise;
  hs_status_t stat_s;

  hs_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .ack_n_i(ack_n),
    .ack_lvl_o(ack_lvl), .ack_rise_o(ack_rise)
  );

  hs_data_reg #(.W(DATA_W)) u_data (
    .clk(clk), .rst(rst), .load_i(wr_stb), .d_i(wr_data), .q_o(port_data)
  );

  hs_flags u_flags (
    .clk(clk), .rst(rst), .wr_i(wr_stb), .en_i(int_en),
    .ack_lvl_i(ack_lvl), .ack_rise_i(ack_rise),
    .obf_n_o(obf_n), .irq_o(irq)
  );

  always_comb begin
    stat_s.obf_n = obf_n;
    stat_s.irq   = irq;
    stat_s.en    = int_en;
  end
  assign status = stat_s;

  always_comb begin
    if (!rst) assert_irq_mask_R8: assert (int_en || !irq);
  end
endmodule

// File: tb/test_hs_strobe_out_port.sv
module test_hs_strobe_out_port;
  localparam int W = 8;

  typedef struct {
    logic         obf_n;
    logic         irq;
    logic [W-1:0] data;
    logic         en;
    string        tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_stb = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic int_en = 1'b0;
  logic ack_n = 1'b1;
  logic obf_n, irq;
  logic [W-1:0] port_data;
  logic [2:0] status;

  int checks = 0;
  int fails  = 0;
  exp_t q[$];
  logic [W-1:0] cur = '0;

  always #10 clk = ~clk;

  hs_strobe_out_port #(.DATA_W(W)) i_hs_strobe_out_port (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_data(wr_data),
    .int_en(int_en), .ack_n(ack_n), .obf_n(obf_n), .irq(irq),
    .port_data(port_data), .status(status)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected items and compares at a quarter period after the edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk({e.tag, " obf_n"}, 32'(obf_n), 32'(e.obf_n));
        chk({e.tag, " irq"}, 32'(irq), 32'(e.irq));
        chk({e.tag, " data"}, 32'(port_data), 32'(e.data));
        chk({"R9 ", e.tag, " status"}, 32'(status), 32'({e.obf_n, e.irq, e.en}));
      end
    end
  end

  task automatic push(input logic eo, input logic ei, input string tag);
    exp_t e;
    e.obf_n = eo; e.irq = ei; e.data = cur; e.en = int_en; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic do_wr(input logic [W-1:0] d);
    wr_stb = 1'b1; wr_data = d; cur = d;
    @(posedge clk);
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic set_ack(input logic v);
    ack_n = v;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); push(1'b1, 1'b0, "R1 reset");

    int_en = 1'b1;
    wr_stb = 1'b1; wr_data = 8'hA5; cur = 8'hA5;
    @(posedge clk); push(1'b0, 1'b0, "R2 write A5");
    wr_stb = 1'b0;

    set_ack(1'b0); push(1'b1, 1'b0, "R3 ack low");
    set_ack(1'b1); push(1'b1, 1'b1, "R5 ack rise");

    wr_stb = 1'b1; wr_data = 8'h3C; cur = 8'h3C;
    @(posedge clk); push(1'b0, 1'b0, "R7 write clears irq");
    wr_stb = 1'b0;

    int_en = 1'b0;
    set_ack(1'b0); push(1'b1, 1'b0, "R3 ack low 2");
    set_ack(1'b1); push(1'b1, 1'b0, "R6 rise disabled");

    int_en = 1'b1;
    set_ack(1'b0); push(1'b1, 1'b0, "R4 repeat ack low");
    set_ack(1'b1); push(1'b1, 1'b1, "R4 repeat ack rise");

    // R8: mask within the same cycle, then no return on re-enable
    int_en = 1'b0;
    #2;
    chk("R8 immediate mask irq", 32'(irq), 32'd0);
    chk("R9 status en off", 32'(status), 32'b100);
    @(negedge clk);
    int_en = 1'b1;
    #2;
    chk("R8 no return on re-enable", 32'(irq), 32'd0);
    @(posedge clk); push(1'b1, 1'b0, "R8 after re-enable");

    // R10: write while acknowledge is held low
    set_ack(1'b0);
    @(negedge clk);
    wr_stb = 1'b1; wr_data = 8'h5A; cur = 8'h5A;
    @(posedge clk); push(1'b0, 1'b0, "R10 write wins");
    wr_stb = 1'b0;
    @(posedge clk); push(1'b1, 1'b0, "R10 re-release");
    set_ack(1'b1); push(1'b1, 1'b1, "R5 rise after R10");

    repeat (3) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 20000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule